// File: doc/BRIEF.md
# UART Transmit Framer

This block turns queued characters into an asynchronous serial frame on a single transmit line. Characters enter through a one-cycle write strobe into a small queue that acts either as a multi-entry buffer or, in character mode, as a single holding slot. Each character leaves as a start bit, 5 to 8 data bits sent least-significant bit first, an optional parity bit (odd, even or forced to a constant), and one or two stop bits. The line rests high between frames.

Bit timing is set by a one-cycle tick input that pulses once per bit period, so the block carries no baud divider. The frame shape is taken from the configuration inputs at the moment a frame starts. Clearing the global enable or the transmit enable, raising the break request, or (when flow control is on) dropping clear-to-send holds back the next start bit but never cuts short the frame already on the line. A break request holds the line low once the current frame has ended. Busy, empty and full flags report the queue and the shifter.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset the line is high, the empty flag is 1, and the full flag and busy are 0.
- R2: A frame starts with a low start bit, followed by the data bits least-significant bit first. The count of data bits comes from the 2-bit length code: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7, 2'b11 gives 8.
- R3: With parity on and the force option off, a parity bit follows the data. When the parity-sense input is 1, the data plus the parity bit hold an even count of ones. When it is 0, they hold an odd count. With parity off, no parity bit is sent.
- R4: With parity on and the force option on, the parity bit is the inverse of the parity-sense input. The force option has no effect while parity is off.
- R5: The frame ends with one high stop bit, or two when the two-stop input is 1. After the stop bits the line returns to idle high.
- R6: While the break input is 1, no new frame starts. Once any frame in flight has ended, the line is held low, starting one cycle after the break input is seen in an idle cycle. Clearing the break input makes the idle line high again one cycle later.
- R7: A new frame starts only while both the global enable and the transmit enable are 1. Clearing either one during a frame lets that frame finish unchanged.
- R8: Busy is 1 from the cycle after a character is accepted, even while transmission is disabled. It stays 1 until the last stop bit of the last queued character has ended.
- R9: With flow control on, a frame starts only while clear-to-send is 1. Dropping clear-to-send during a frame does not shorten that frame.
- R10: The queue holds DEPTH characters when the buffer-mode input is 1 and one character when it is 0. The full flag is 1 at that capacity. A write while full is dropped and leaves the queue unchanged.
- R11: A frame starts only on a tick, and the line falls one cycle after that tick. Each later tick moves the line to the next bit one cycle later, so every bit lasts one tick period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| wr_valid | input | 1 | Write strobe for one character |
| wr_data | input | 8 | Character to queue |
| buf_mode | input | 1 | 1: multi-entry queue, 0: single holding slot |
| len_code | input | 2 | Data bit count code |
| par_on | input | 1 | Parity bit enable |
| par_even | input | 1 | Parity sense, 1 even, 0 odd |
| par_force | input | 1 | Parity bit forced to the inverse of par_even |
| stop2 | input | 1 | Two stop bits |
| brk_req | input | 1 | Hold the line low after the current frame |
| glob_en | input | 1 | Global enable |
| tx_en | input | 1 | Transmit enable |
| flow_en | input | 1 | Clear-to-send gating enable |
| cts | input | 1 | Clear-to-send, active high |
| txd | output | 1 | Serial output line |
| busy | output | 1 | Queue not empty or frame in flight |
| q_empty | output | 1 | Queue empty |
| q_full | output | 1 | Queue at capacity |

## Verification
The empty, full and busy flags change in the cycle after the write or start edge that affects them. The line falls in the cycle after the start tick and moves to each next bit in the cycle after each later tick. A break request or its release shows on an idle line one cycle later. The reference model in the bench updates on the same rising edge as the design, from the same inputs. All four outputs are compared against it at the falling edge of every cycle, and inputs change only just after a rising edge. A wrong cycle count in any of these paths therefore shows as a mismatch in the cycle where the value is due.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
package uart_tx_pkg;
   localparam int CHAR_W  = 8;
   localparam int FRAME_W = 1 + CHAR_W + 1 + 2;
   localparam int LEN_W   = $clog2(FRAME_W + 1);

   typedef enum logic [1:0] {
      LEN5 = 2'b00,
      LEN6 = 2'b01,
      LEN7 = 2'b10,
      LEN8 = 2'b11
   } len_code_e;

   typedef struct packed {
      len_code_e len;
      logic      par_on;
      logic      par_even;
      logic      par_force;
      logic      stop2;
   } frame_cfg_t;
endpackage

// File: rtl/uart_tx_queue.sv
`timescale 1ns/1ps
module uart_tx_queue #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             buf_mode,
   input  logic             push_req,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] CAP_BUF  = CW'(DEPTH);
   localparam logic [CW-1:0] CAP_CHAR = CW'(1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("uart_tx_queue: DEPTH must be a power of two, at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("uart_tx_queue: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    rd_ptr, wr_ptr;
   logic [CW-1:0]    cnt;
   logic [CW-1:0]    cap;
   logic             do_push, do_pop;

   assign cap     = buf_mode ? CAP_BUF : CAP_CHAR;
   assign full    = (cnt >= cap);
   assign empty   = (cnt == '0);
   assign do_push = push_req && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + AW'(1);
         if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   // R10: never more entries than the largest capacity
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CAP_BUF);

   // R10: a write while full with no pop leaves the count unchanged
   p_full_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push_req && !pop) |=> $stable(cnt));
endmodule

// File: rtl/uart_tx_frame_build.sv
`timescale 1ns/1ps
module uart_tx_frame_build
   import uart_tx_pkg::*;
(
   input  logic [CHAR_W-1:0]  data,
   input  frame_cfg_t         cfg,
   output logic [FRAME_W-1:0] frame,
   output logic [LEN_W-1:0]   len
);
   logic [3:0]        nbits;
   logic [CHAR_W-1:0] keep;
   logic [CHAR_W-1:0] masked;
   logic              ones_odd;
   logic              par_bit;
   logic [3:0]        par_pos;

   assign nbits = 4'd5 + {2'b00, cfg.len};

   genvar gi;
   generate
      for (gi = 0; gi < CHAR_W; gi++) begin : g_keep
         assign keep[gi] = (4'(gi) < nbits);
      end
   endgenerate

   assign masked   = data & keep;
   assign ones_odd = ^masked;

   always_comb begin
      if (cfg.par_force) par_bit = ~cfg.par_even;
      else if (cfg.par_even) par_bit = ones_odd;
      else par_bit = ~ones_odd;
   end

   assign par_pos = 4'd1 + nbits;

   always_comb begin
      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < CHAR_W; i++) begin
         if (keep[i]) frame[1 + i] = data[i];
      end
      if (cfg.par_on) frame[par_pos] = par_bit;
   end

   assign len = LEN_W'(2) + LEN_W'(nbits) + LEN_W'(cfg.par_on) + LEN_W'(cfg.stop2);
endmodule

// File: rtl/uart_tx_shifter.sv
`timescale 1ns/1ps
module uart_tx_shifter
   import uart_tx_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_tick,
   input  logic               have_data,
   input  logic               glob_en,
   input  logic               tx_en,
   input  logic               flow_en,
   input  logic               cts,
   input  logic               brk_req,
   input  logic [FRAME_W-1:0] frame,
   input  logic [LEN_W-1:0]   len,
   output logic               pop,
   output logic               active,
   output logic               txd
);
   logic [FRAME_W-1:0] shreg;
   logic [LEN_W-1:0]   remain;
   logic               allowed;
   logic               start;

   assign allowed = glob_en && tx_en && (!flow_en || cts) && !brk_req;
   assign start   = bit_tick && !active && have_data && allowed;
   assign pop     = start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         txd    <= 1'b1;
         shreg  <= '1;
         remain <= '0;
      end else if (start) begin
         active <= 1'b1;
         txd    <= frame[0];
         shreg  <= {1'b1, frame[FRAME_W-1:1]};
         remain <= len;
      end else if (active && bit_tick) begin
         if (remain == LEN_W'(1)) begin
            active <= 1'b0;
            txd    <= ~brk_req;
         end else begin
            txd    <= shreg[0];
            shreg  <= {1'b1, shreg[FRAME_W-1:1]};
            remain <= remain - LEN_W'(1);
         end
      end else if (!active) begin
         txd <= ~brk_req;
      end
   end

   // R2: the first bit of every frame is low
   p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> !txd);

   // R11: frames begin only on a tick
   p_start_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(bit_tick));

   // R7: frames begin only while both enables are set
   p_enable_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(glob_en && tx_en));

   // R9: with flow control, a frame begins only under clear-to-send
   p_cts_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(active) && $past(flow_en)) |-> $past(cts));

   // R6: an idle cycle with break requested holds the line low next cycle
   p_break_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && brk_req) |=> !txd);
endmodule

// File: rtl/uart_tx_framer.sv
`timescale 1ns/1ps
module uart_tx_framer
   import uart_tx_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_tick,
   input  logic       wr_valid,
   input  logic [7:0] wr_data,
   input  logic       buf_mode,
   input  logic [1:0] len_code,
   input  logic       par_on,
   input  logic       par_even,
   input  logic       par_force,
   input  logic       stop2,
   input  logic       brk_req,
   input  logic       glob_en,
   input  logic       tx_en,
   input  logic       flow_en,
   input  logic       cts,
   output logic       txd,
   output logic       busy,
   output logic       q_empty,
   output logic       q_full
);
   logic [CHAR_W-1:0]  head;
   logic               pop;
   logic               active;
   frame_cfg_t         cfg;
   logic [FRAME_W-1:0] frame;
   logic [LEN_W-1:0]   len;

   assign cfg.len       = len_code_e'(len_code);
   assign cfg.par_on    = par_on;
   assign cfg.par_even  = par_even;
   assign cfg.par_force = par_force;
   assign cfg.stop2     = stop2;

   uart_tx_queue #(.DEPTH(DEPTH), .WIDTH(CHAR_W)) i_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .buf_mode  (buf_mode),
      .push_req  (wr_valid),
      .push_data (wr_data),
      .pop       (pop),
      .head      (head),
      .empty     (q_empty),
      .full      (q_full)
   );

   uart_tx_frame_build i_build (
      .data  (head),
      .cfg   (cfg),
      .frame (frame),
      .len   (len)
   );

   uart_tx_shifter i_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_tick  (bit_tick),
      .have_data (!q_empty),
      .glob_en   (glob_en),
      .tx_en     (tx_en),
      .flow_en   (flow_en),
      .cts       (cts),
      .brk_req   (brk_req),
      .frame     (frame),
      .len       (len),
      .pop       (pop),
      .active    (active),
      .txd       (txd)
   );

   assign busy = !q_empty || active;

   // R8: an accepted write makes busy high in the next cycle
   p_busy_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !q_full) |=> busy);
endmodule

// File: tb/test_uart_tx_framer.sv
`timescale 1ns/1ps
module test_uart_tx_framer;
   localparam int DEPTH = 4;
   localparam int TDIV  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_data = '0;
   logic       buf_mode = 1'b1;
   logic [1:0] len_code = 2'b11;
   logic       par_on = 1'b0, par_even = 1'b0, par_force = 1'b0, stop2 = 1'b0;
   logic       brk_req = 1'b0, glob_en = 1'b1, tx_en = 1'b1, flow_en = 1'b0, cts = 1'b1;
   logic       txd, busy, q_empty, q_full;

   int    checks = 0;
   int    errors = 0;
   int    cycles = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   uart_tx_framer #(.DEPTH(DEPTH)) i_uart_tx_framer (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_valid(wr_valid),
      .wr_data(wr_data), .buf_mode(buf_mode), .len_code(len_code),
      .par_on(par_on), .par_even(par_even), .par_force(par_force),
      .stop2(stop2), .brk_req(brk_req), .glob_en(glob_en), .tx_en(tx_en),
      .flow_en(flow_en), .cts(cts), .txd(txd), .busy(busy),
      .q_empty(q_empty), .q_full(q_full));

   // tick generator: one pulse every TDIV cycles, changed just after the edge
   int tick_cnt = 0;
   always @(posedge clk) begin
      #2;
      tick_cnt = tick_cnt + 1;
      bit_tick = (tick_cnt % TDIV == 0);
   end

   // reference model
   int q[$];
   bit m_bits[$];
   bit m_active = 0;
   bit m_txd = 1;
   int m_sz0, m_cap, m_n, m_ones;
   bit m_start, m_pb;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete(); m_bits.delete(); m_active = 0; m_txd = 1;
      end else begin
         m_sz0 = q.size();
         m_cap = buf_mode ? DEPTH : 1;
         m_start = bit_tick && !m_active && (m_sz0 > 0) && glob_en && tx_en &&
                   (!flow_en || cts) && !brk_req;
         if (m_start) begin
            m_n = 5 + int'(len_code);
            m_ones = 0;
            m_bits.delete();
            for (int i = 0; i < m_n; i++) begin
               m_bits.push_back(q[0][i]);
               if (q[0][i]) m_ones++;
            end
            if (par_on) begin
               if (par_force) m_pb = !par_even;
               else if (par_even) m_pb = (m_ones % 2 == 1);
               else m_pb = (m_ones % 2 == 0);
               m_bits.push_back(m_pb);
            end
            m_bits.push_back(1'b1);
            if (stop2) m_bits.push_back(1'b1);
            void'(q.pop_front());
            m_active = 1; m_txd = 0;
         end else if (m_active && bit_tick) begin
            if (m_bits.size() == 0) begin
               m_active = 0; m_txd = !brk_req;
            end else begin
               m_txd = m_bits.pop_front();
            end
         end else if (!m_active) begin
            m_txd = !brk_req;
         end
         if (wr_valid && m_sz0 < m_cap) q.push_back(int'(wr_data));
      end
   end

   task automatic check_bit(string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %b expected %b at cycle %0d", cur_req, what, act, exp, cycles);
      end
   endtask

   // compare every cycle, mid-cycle
   always @(negedge clk) begin
      if (rst_n) begin
         check_bit("txd", txd, m_txd);
         check_bit("busy", busy, (q.size() > 0) || m_active);
         check_bit("q_empty", q_empty, q.size() == 0);
         check_bit("q_full", q_full, q.size() >= (buf_mode ? DEPTH : 1));
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual %0d expected below 150000", cycles);
         finish_run();
      end
   end

   task automatic step(int n);
      repeat (n) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic put(logic [7:0] b);
      wr_valid = 1'b1; wr_data = b;
      step(1);
      wr_valid = 1'b0;
   endtask

   task automatic drain();
      int guard = 0;
      while ((m_active || q.size() > 0) && guard < 5000) begin
         step(1); guard++;
      end
      step(6);
   endtask

   task automatic send_cfg(logic [1:0] lc, logic pon, logic pev, logic pfo, logic s2,
                           logic [7:0] b);
      len_code = lc; par_on = pon; par_even = pev; par_force = pfo; stop2 = s2;
      put(b);
      drain();
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset values
      cur_req = "R1";
      check_bit("txd reset", txd, 1'b1);
      check_bit("q_empty reset", q_empty, 1'b1);
      check_bit("q_full reset", q_full, 1'b0);
      check_bit("busy reset", busy, 1'b0);
      step(2);

      // R2 / R11: each length code, no parity
      cur_req = "R2";
      send_cfg(2'b11, 0, 0, 0, 0, 8'hA5);
      send_cfg(2'b10, 0, 0, 0, 0, 8'hD3);
      send_cfg(2'b01, 0, 0, 0, 0, 8'h6E);
      send_cfg(2'b00, 0, 0, 0, 0, 8'hF1);
      cur_req = "R11";
      send_cfg(2'b11, 0, 0, 0, 0, 8'h01);

      // R3: even and odd parity
      cur_req = "R3";
      send_cfg(2'b11, 1, 1, 0, 0, 8'h07);
      send_cfg(2'b11, 1, 0, 0, 0, 8'h07);
      send_cfg(2'b10, 1, 1, 0, 0, 8'hFF);
      send_cfg(2'b00, 1, 0, 0, 0, 8'hE0);

      // R4: forced parity both senses, and force with parity off
      cur_req = "R4";
      send_cfg(2'b11, 1, 0, 1, 0, 8'h00);
      send_cfg(2'b11, 1, 1, 1, 0, 8'hFF);
      send_cfg(2'b01, 0, 1, 1, 0, 8'h2A);

      // R5: two stop bits
      cur_req = "R5";
      send_cfg(2'b11, 0, 0, 0, 1, 8'h55);
      send_cfg(2'b00, 1, 1, 0, 1, 8'h13);

      // R8 and R10: queue fills while disabled, extra writes dropped
      cur_req = "R8";
      len_code = 2'b11; par_on = 0; stop2 = 0;
      tx_en = 1'b0;
      put(8'h11);
      step(5);
      cur_req = "R10";
      for (int i = 0; i < DEPTH + 2; i++) put(8'(8'h20 + i));
      step(4);
      tx_en = 1'b1;
      drain();
      buf_mode = 1'b0;
      glob_en = 1'b0;
      put(8'h3C);
      put(8'hC3);
      step(4);
      glob_en = 1'b1;
      drain();
      buf_mode = 1'b1;

      // R7: disable mid-frame
      cur_req = "R7";
      put(8'h96);
      put(8'h69);
      step(14);
      glob_en = 1'b0;
      step(80);
      glob_en = 1'b1;
      step(14);
      tx_en = 1'b0;
      step(80);
      tx_en = 1'b1;
      drain();

      // R6: break during a frame, second character held
      cur_req = "R6";
      put(8'hAA);
      put(8'h0F);
      step(10);
      brk_req = 1'b1;
      step(100);
      brk_req = 1'b0;
      drain();

      // R9: flow control
      cur_req = "R9";
      flow_en = 1'b1; cts = 1'b0;
      put(8'h5A);
      step(30);
      cts = 1'b1;
      step(10);
      cts = 1'b0;
      step(80);
      put(8'hB4);
      step(30);
      cts = 1'b1;
      drain();
      flow_en = 1'b0;

      finish_run();
   end
endmodule